// File: doc/BRIEF.md
# Two-lane ADC sample word reassembler

This block turns the serial bit streams of a high-speed converter back into parallel sample words. Upstream capture logic delivers, on every core clock, two bits per data lane: the bit taken on the rising bit-clock edge and the bit taken on the falling edge. The block can use one lane or two. A frame marker, asserted in the cycle that carries the first bit of a sample, sets the word boundary. Once a frame has been collected, the block presents the finished sample right-aligned in a 16-bit word, together with a one-cycle valid strobe.

The lane setup, the lane split, the bit order and the resolution are all chosen by configuration inputs. These inputs are taken only while the block is idle. A 14-bit converter that sends 16 bit times per frame has its two trailing filler bits removed. In single-lane mode, two converters can share one lane: the rising-edge stream and the falling-edge stream each build their own sample. If a frame marker arrives at a cycle where none is expected, a sticky flag is raised, and the flag stays set until a resync or a reset.

Top module: `adc_word_reasm`

## Requirements
- R1: While reset is low, and until the first frame has completed, `valid_o`, `misalign_o`, `word0_o` and `word1_o` are all zero.
- R2: With `two_wire_i`=0 only lane 0 is used. Each cycle supplies two consecutive stream bits, the rising-edge bit before the falling-edge bit, and a frame of F bits occupies F/2 cycles. Lane 1 inputs have no effect.
- R3: With `lsb_first_i`=1 the first stream bit of each lane is the lowest bit that lane carries. With `lsb_first_i`=0 it is the highest bit, and the following bits run in descending order.
- R4: With `two_wire_i`=1 and `bytewise_i`=0, lane 0 carries the odd bit positions and lane 1 carries the even ones. Each lane carries F/2 bits (rising edge first), and a frame occupies F/4 cycles.
- R5: With `two_wire_i`=1 and `bytewise_i`=1, lane 0 carries frame bits F-1 down to F/2 and lane 1 carries bits F/2-1 down to 0.
- R6: `res_i` selects the resolution: 0 gives 12 bits, 1 gives 14 bits, and 2 or 3 give 16 bits. The sample is placed right-aligned in the output word, and the unused upper bits are zero.
- R7: At 14-bit resolution with `pad14_i`=1, or in two-lane mode, the frame is F=16 bit times. The sample is frame bits 15..2, and frame bits 1..0 are discarded.
- R8: With `dual_i`=1 and `two_wire_i`=0, the rising-edge bits of lane 0 form the sample on `word0_o` and the falling-edge bits form the sample on `word1_o`. Each sample spans F cycles. In two-lane mode `dual_i` is ignored. Whenever dual operation is off, `word1_o` is zero at every strobe.
- R9: `valid_o` pulses high for exactly one cycle, in the cycle after the last data cycle of a frame. The output words change only together with that pulse.
- R10: While idle, lane bits are ignored. The first frame marker starts a frame, and the cycle that carries the marker is cycle 0 of that frame. After that, frames follow back to back without any gap.
- R11: A frame marker seen while running, in any cycle other than cycle 0 of a frame, sets `misalign_o` from the next cycle onward. The flag holds until a resync or a reset, and the frame count is not disturbed.
- R12: The configuration inputs are captured only while idle. Changing them while frames are running has no effect until a resync has been done.
- R13: A `resync_i` pulse returns the block to idle and clears `misalign_o`. In the following cycle `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one lane bit pair per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| resync_i | input | 1 | Return to idle and re-read the configuration |
| two_wire_i | input | 1 | 1 = each sample split over two lanes |
| bytewise_i | input | 1 | Two-lane split: 1 = upper/lower half, 0 = odd/even bits |
| lsb_first_i | input | 1 | 1 = streams start with the lowest bit |
| res_i | input | 2 | Resolution code: 0 = 12, 1 = 14, 2/3 = 16 bits |
| pad14_i | input | 1 | 14-bit samples sent in 16 bit times |
| dual_i | input | 1 | Two converters sharing lane 0, one per clock edge |
| lane_rise_i | input | 2 | Rising-edge bit of each lane (bit n = lane n) |
| lane_fall_i | input | 2 | Falling-edge bit of each lane (bit n = lane n) |
| frame_i | input | 1 | Frame marker, high in the cycle carrying bit time 0 |
| word0_o | output | 16 | Reassembled sample, right-aligned |
| word1_o | output | 16 | Second converter sample in dual mode, otherwise zero |
| valid_o | output | 1 | One-cycle strobe marking new output words |
| misalign_o | output | 1 | Sticky unexpected frame-marker flag |

## Verification
Random sample words are serialized under each configuration that matters. These are single-lane at 12, 14 and 16 bits in both bit orders, 14 bits padded to 16, both two-lane splits, and dual-converter sharing with dual requested in two-lane mode as well. A wrong split, a wrong order or a wrong pad strip shows up as a scrambled word, and a wrong cycles-per-frame count shows up as a shifted valid strobe. Random lane-1 bits in single-lane mode and random data during idle show whether ignored inputs leak into the output. A stray frame marker, a configuration change made mid-run and a resync together separate a sticky flag and a configuration captured only at idle from logic that reacts immediately.

// File: rtl/adc_wa_pkg.sv
package adc_wa_pkg;

  localparam int WORD_W = 16;
  localparam int IDX_W  = $clog2(WORD_W);
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int POS_W  = IDX_W + 2;
  localparam int LANES  = 2;
  localparam int EDGES  = 2;
  localparam int SLOTS  = LANES * EDGES;
  localparam int RES_LO = 12;
  localparam int RES_MD = 14;
  localparam int PAD_W  = WORD_W - RES_MD;

  typedef struct packed {
    logic       two_wire;
    logic       bytewise;
    logic       lsb_first;
    logic [1:0] res;
    logic       pad14;
    logic       dual;
  } cfg_t;

  typedef struct packed {
    logic             en;
    logic             sel;
    logic [IDX_W-1:0] idx;
  } slot_t;

  typedef enum logic {ST_IDLE, ST_RUN} state_e;

  // bit times in one frame
  function automatic logic [POS_W-1:0] frame_bits(cfg_t c);
    if (c.res == 2'd0)                                 return POS_W'(RES_LO);
    else if (c.res == 2'd1 && !c.pad14 && !c.two_wire) return POS_W'(RES_MD);
    else                                               return POS_W'(WORD_W);
  endfunction

  function automatic logic dual_on(cfg_t c);
    return c.dual & ~c.two_wire;
  endfunction

  function automatic logic [POS_W-1:0] cyc_per_frame(cfg_t c);
    logic [POS_W-1:0] f;
    f = frame_bits(c);
    if (dual_on(c))      return f;
    else if (c.two_wire) return f >> 2;
    else                 return f >> 1;
  endfunction

  function automatic logic padded(cfg_t c);
    return (c.res == 2'd1) && (frame_bits(c) == POS_W'(WORD_W));
  endfunction

  // destination of one captured bit inside the frame word
  function automatic slot_t map_slot(cfg_t c, logic [CNT_W-1:0] cnt,
                                     logic lane, logic edg);
    logic [POS_W-1:0] f, n, len, p, t;
    slot_t s;
    f   = frame_bits(c);
    n   = dual_on(c) ? POS_W'(cnt) : POS_W'({cnt, edg});
    len = c.two_wire ? (f >> 1) : f;
    p   = c.lsb_first ? n : (len - POS_W'(1) - n);
    if (c.two_wire && !c.bytewise)
      t = POS_W'(p << 1) | POS_W'(!lane);
    else if (c.two_wire)
      t = p + (lane ? POS_W'(0) : (f >> 1));
    else
      t = p;
    s.en  = c.two_wire | ~lane;
    s.sel = dual_on(c) & edg;
    s.idx = IDX_W'(t);
    return s;
  endfunction

endpackage

// File: rtl/adc_wa_rst_sync.sv
module adc_wa_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/adc_wa_seq.sv
module adc_wa_seq
  import adc_wa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             resync_i,
  input  logic             frame_i,
  input  cfg_t             cfg_i,
  output cfg_t             cfg_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             active_o,
  output logic             first_o,
  output logic             last_o,
  output logic             misalign_o
);
  state_e           state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             mis_q, mis_n;
  cfg_t             cfg_q;
  logic             idle, cfg_en;
  logic [POS_W-1:0] cyc;

  always_comb begin
    idle     = (state_q == ST_IDLE);
    cfg_en   = idle;
    cfg_o    = idle ? cfg_i : cfg_q;
    cyc      = cyc_per_frame(cfg_o);
    cnt_o    = idle ? '0 : cnt_q;
    active_o = !resync_i && (!idle || frame_i);
    first_o  = (cnt_o == '0);
    last_o   = active_o && (POS_W'(cnt_o) == cyc - POS_W'(1));

    state_n = state_q;
    cnt_n   = cnt_q;
    mis_n   = mis_q;
    if (resync_i) begin
      state_n = ST_IDLE;
      cnt_n   = '0;
      mis_n   = 1'b0;
    end else if (active_o) begin
      state_n = ST_RUN;
      cnt_n   = last_o ? '0 : CNT_W'(cnt_o + 1'b1);
      if (!idle && frame_i && cnt_q != '0) mis_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mis_q   <= 1'b0;
      cfg_q   <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      mis_q   <= mis_n;
      if (cfg_en) cfg_q <= cfg_i;
    end
  end

  assign misalign_o = mis_q;
endmodule

// File: rtl/adc_wa_map.sv
module adc_wa_map
  import adc_wa_pkg::*;
(
  input  cfg_t                   cfg_i,
  input  logic [CNT_W-1:0]       cnt_i,
  output slot_t [SLOTS-1:0]      slot_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    for (genvar e = 0; e < EDGES; e++) begin : g_edge
      assign slot_o[l*EDGES+e] = map_slot(cfg_i, cnt_i, 1'(l), 1'(e));
    end
  end
endmodule

// File: rtl/adc_wa_asm.sv
module adc_wa_asm
  import adc_wa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_t              cfg_i,
  input  logic              active_i,
  input  logic              first_i,
  input  logic              last_i,
  input  slot_t [SLOTS-1:0] slot_i,
  input  logic [SLOTS-1:0]  bit_i,
  output logic [WORD_W-1:0] word0_o,
  output logic [WORD_W-1:0] word1_o,
  output logic              valid_o
);
  logic [1:0][WORD_W-1:0] acc_q, acc_n;
  logic [WORD_W-1:0]      w0_q, w1_q, w0_n, w1_n;
  logic                   valid_q;
  logic                   acc_en, out_en;

  always_comb begin
    acc_n = first_i ? '0 : acc_q;
    for (int s = 0; s < SLOTS; s++) begin
      if (slot_i[s].en) acc_n[slot_i[s].sel][slot_i[s].idx] = bit_i[s];
    end
    acc_en = active_i;
    out_en = last_i;
    w0_n   = padded(cfg_i) ? (acc_n[0] >> PAD_W) : acc_n[0];
    w1_n   = !dual_on(cfg_i) ? '0 :
             (padded(cfg_i) ? (acc_n[1] >> PAD_W) : acc_n[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      w0_q    <= '0;
      w1_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= last_i;
      if (acc_en) acc_q <= acc_n;
      if (out_en) begin
        w0_q <= w0_n;
        w1_q <= w1_n;
      end
    end
  end

  assign word0_o = w0_q;
  assign word1_o = w1_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/adc_word_reasm.sv
module adc_word_reasm
  import adc_wa_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        resync_i,
  input  logic        two_wire_i,
  input  logic        bytewise_i,
  input  logic        lsb_first_i,
  input  logic [1:0]  res_i,
  input  logic        pad14_i,
  input  logic        dual_i,
  input  logic [1:0]  lane_rise_i,
  input  logic [1:0]  lane_fall_i,
  input  logic        frame_i,
  output logic [15:0] word0_o,
  output logic [15:0] word1_o,
  output logic        valid_o,
  output logic        misalign_o
);
  logic              rst_s_n;
  cfg_t              cfg_in, cfg_eff;
  logic [CNT_W-1:0]  cnt;
  logic              active, first, last;
  slot_t [SLOTS-1:0] slots;
  logic [SLOTS-1:0]  bits;

  always_comb begin
    cfg_in.two_wire  = two_wire_i;
    cfg_in.bytewise  = bytewise_i;
    cfg_in.lsb_first = lsb_first_i;
    cfg_in.res       = res_i;
    cfg_in.pad14     = pad14_i;
    cfg_in.dual      = dual_i;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_bits
    assign bits[l*EDGES]     = lane_rise_i[l];
    assign bits[l*EDGES + 1] = lane_fall_i[l];
  end

  adc_wa_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  adc_wa_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .resync_i   (resync_i),
    .frame_i    (frame_i),
    .cfg_i      (cfg_in),
    .cfg_o      (cfg_eff),
    .cnt_o      (cnt),
    .active_o   (active),
    .first_o    (first),
    .last_o     (last),
    .misalign_o (misalign_o)
  );

  adc_wa_map u_map (
    .cfg_i  (cfg_eff),
    .cnt_i  (cnt),
    .slot_o (slots)
  );

  adc_wa_asm u_asm (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .cfg_i    (cfg_eff),
    .active_i (active),
    .first_i  (first),
    .last_i   (last),
    .slot_i   (slots),
    .bit_i    (bits),
    .word0_o  (word0_o),
    .word1_o  (word1_o),
    .valid_o  (valid_o)
  );
endmodule

// File: rtl/adc_word_reasm_chk.sv
module adc_word_reasm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        resync_i,
  input logic [15:0] word0_o,
  input logic [15:0] word1_o,
  input logic        valid_o,
  input logic        misalign_o
);
  // R9
  valid_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R9
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> ($stable(word0_o) && $stable(word1_o)));

  // R11
  misalign_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (misalign_o && !resync_i) |=> misalign_o);

  // R13
  resync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync_i |=> (!misalign_o && !valid_o));
endmodule

bind adc_word_reasm adc_word_reasm_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .resync_i   (resync_i),
  .word0_o    (word0_o),
  .word1_o    (word1_o),
  .valid_o    (valid_o),
  .misalign_o (misalign_o)
);

// File: tb/adc_word_reasm_bench.sv
module adc_word_reasm_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        resync_i, two_wire_i, bytewise_i, lsb_first_i, pad14_i, dual_i, frame_i;
  logic [1:0]  res_i, lane_rise_i, lane_fall_i;
  logic [15:0] word0_o, word1_o;
  logic        valid_o, misalign_o;

  int n_chk = 0;
  int n_err = 0;
  logic        exp_valid, exp_mis;
  logic [15:0] exp_w0, exp_w1;
  // model configuration (what the block should have captured)
  logic m_two, m_byte, m_lsb, m_pad, m_dual;
  logic [1:0] m_res;

  always #5 clk = ~clk;

  adc_word_reasm u_adc_word_reasm (
    .clk(clk), .rst_n(rst_n), .resync_i(resync_i), .two_wire_i(two_wire_i),
    .bytewise_i(bytewise_i), .lsb_first_i(lsb_first_i), .res_i(res_i),
    .pad14_i(pad14_i), .dual_i(dual_i), .lane_rise_i(lane_rise_i),
    .lane_fall_i(lane_fall_i), .frame_i(frame_i), .word0_o(word0_o),
    .word1_o(word1_o), .valid_o(valid_o), .misalign_o(misalign_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(input string vtag, input string wtag, input string mtag);
    chk(vtag, "valid_o", {15'd0, valid_o}, {15'd0, exp_valid});
    chk(mtag, "misalign_o", {15'd0, misalign_o}, {15'd0, exp_mis});
    chk(wtag, "word0_o", word0_o, exp_w0);
    chk(wtag, "word1_o", word1_o, exp_w1);
  endtask

  // one clock: drive after falling edge, compare at next falling edge
  task automatic step(input logic fr, input logic [1:0] r, input logic [1:0] f,
                      input logic rs, input logic ev, input logic [15:0] e0,
                      input logic [15:0] e1, input logic mset,
                      input string vtag, input string wtag, input string mtag);
    frame_i = fr; lane_rise_i = r; lane_fall_i = f; resync_i = rs;
    @(posedge clk);
    @(negedge clk);
    if (rs)   exp_mis = 1'b0;
    if (mset) exp_mis = 1'b1;
    exp_valid = ev;
    if (ev) begin exp_w0 = e0; exp_w1 = e1; end
    compare_all(vtag, wtag, mtag);
  endtask

  task automatic idle_cycles(input int n, input string tag);
    for (int i = 0; i < n; i++)
      step(1'b0, 2'($urandom), 2'($urandom), 1'b0, 1'b0, 16'd0, 16'd0, 1'b0,
           "R10", tag, "R11");
  endtask

  task automatic reconfig(input logic two, input logic byt, input logic lsb,
                          input logic [1:0] res, input logic pad, input logic dual);
    step(1'b0, 2'b00, 2'b00, 1'b1, 1'b0, 16'd0, 16'd0, 1'b0, "R13", "R13", "R13");
    two_wire_i = two; bytewise_i = byt; lsb_first_i = lsb;
    res_i = res; pad14_i = pad; dual_i = dual;
    m_two = two; m_byte = byt; m_lsb = lsb; m_res = res; m_pad = pad; m_dual = dual;
    idle_cycles(2, "R10");
  endtask

  task automatic send_frame(input string tag, input int mis_at);
    int s0[$];
    int s1[$];
    int fb, cyc, half;
    logic de, pd;
    logic [15:0] a, b, wa, wb, msk, e0, e1;
    logic [1:0] r, f;
    fb   = (m_res == 2'd0) ? 12 : ((m_res == 2'd1 && !m_pad && !m_two) ? 14 : 16);
    de   = m_dual && !m_two;
    pd   = (m_res == 2'd1) && (fb == 16);
    half = fb / 2;
    cyc  = de ? fb : (m_two ? fb / 4 : fb / 2);
    msk  = (m_res == 2'd0) ? 16'h0FFF : ((m_res == 2'd1) ? 16'h3FFF : 16'hFFFF);
    a  = 16'($urandom) & msk;
    b  = 16'($urandom) & msk;
    wa = pd ? {a[13:0], 2'($urandom)} : a;
    wb = pd ? {b[13:0], 2'($urandom)} : b;
    e0 = a;
    e1 = de ? b : 16'd0;
    if (!m_two) begin
      for (int i = 0; i < fb; i++) s0.push_back(i);
    end else if (!m_byte) begin
      for (int i = 0; i < half; i++) begin s0.push_back(2*i + 1); s1.push_back(2*i); end
    end else begin
      for (int i = 0; i < half; i++) begin s0.push_back(half + i); s1.push_back(i); end
    end
    if (!m_lsb) begin s0.reverse(); s1.reverse(); end
    for (int c = 0; c < cyc; c++) begin
      r = 2'($urandom);
      f = 2'($urandom);
      if (de) begin
        r[0] = wa[s0[c]]; f[0] = wb[s0[c]];
      end else begin
        r[0] = wa[s0[2*c]]; f[0] = wa[s0[2*c+1]];
        if (m_two) begin r[1] = wa[s1[2*c]]; f[1] = wa[s1[2*c+1]]; end
      end
      step((c == 0) || (c == mis_at), r, f, 1'b0, (c == cyc - 1), e0, e1,
           (c == mis_at), "R9", tag, "R11");
    end
  endtask

  task automatic frames(input int n, input string tag);
    for (int i = 0; i < n; i++) send_frame(tag, -1);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0; resync_i = 1'b0; frame_i = 1'b0;
    two_wire_i = 1'b0; bytewise_i = 1'b0; lsb_first_i = 1'b0;
    res_i = 2'd0; pad14_i = 1'b0; dual_i = 1'b0;
    lane_rise_i = 2'b11; lane_fall_i = 2'b11;
    m_two = 0; m_byte = 0; m_lsb = 0; m_res = 0; m_pad = 0; m_dual = 0;
    exp_valid = 0; exp_mis = 0; exp_w0 = 0; exp_w1 = 0;
    repeat (3) @(negedge clk);
    compare_all("R1", "R1", "R1");
    rst_n = 1'b1;
    idle_cycles(4, "R1");
    // R2: single lane, 12 bit, MSB first
    frames(3, "R2");
    // R12: change inputs mid-run, old capture stays in force
    lsb_first_i = 1'b1; res_i = 2'd2; two_wire_i = 1'b1;
    frames(2, "R12");
    // R3: LSB first, 14 bit in 7 cycles
    reconfig(0, 0, 1, 2'd1, 0, 0);
    frames(3, "R3");
    // R6: 16 bit, then a stray marker for R11
    reconfig(0, 0, 0, 2'd2, 0, 0);
    frames(2, "R6");
    send_frame("R11", 3);
    frames(2, "R11");
    // R7: padded 14 bit
    reconfig(0, 0, 0, 2'd1, 1, 0);
    frames(3, "R7");
    // R4: two lanes, odd/even split
    reconfig(1, 0, 0, 2'd2, 0, 0);
    frames(3, "R4");
    // R5: two lanes, halves, 12 bit LSB first
    reconfig(1, 1, 1, 2'd0, 0, 0);
    frames(3, "R5");
    // R7: two lanes force 16 bit times at 14 bit
    reconfig(1, 1, 0, 2'd1, 0, 0);
    frames(3, "R7");
    // R8: two converters on one lane
    reconfig(0, 0, 0, 2'd0, 0, 1);
    frames(3, "R8");
    // R8: dual ignored in two-lane mode
    reconfig(1, 0, 1, 2'd3, 0, 1);
    frames(3, "R8");
    idle_cycles(3, "R10");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule